// File: doc/BRIEF.md
# Flash Read Response Multiplexer

This block is the read path of a NOR-style parallel flash model. Each read strobe comes with the device's current command state, a byte offset, an access width and a byte-order select. Depending on the state, the block returns one of four things: array contents, identification words, a status byte whose bit 6 flips on every read, or a byte from a small query table. The array itself lives outside the block. The block drives the wrapped array byte address and takes back four consecutive array bytes, which it assembles into the requested width and byte order.

The response is registered. Data appears on `rd_data_o` one clock after the strobe and is held until the next strobe. The status byte lives in this block. The write sequencer loads it when a program or erase starts or finishes, and the read path inverts bit 6 on each status read. A read taken in a command state that has no defined meaning returns array data and raises a one-cycle pulse asking the sequencer to drop back to read mode.

Top module: `flash_read_mux`

## Requirements
- R1: While `rst_n` is low and after it is released, `rd_data_o` is 0, `seq_reset_o` is 0 and the internal status byte is 0.
- R2: In command states 0 (read) and 1 (erase setup), a read returns array bytes starting at the offset. `width_i` 0 gives one byte in bits 7:0. `width_i` 1 gives two bytes, and `width_i` 2 gives four bytes. Little-endian puts the lowest-addressed byte in the least significant lane. `big_endian_i`=1 puts it in the most significant used lane. Unused upper bits are 0.
- R3: The array address `arr_addr_o` is the offset modulo the chip length (2^CHIP_LOG2 bytes), so offsets beyond the chip alias onto it.
- R4: In command state 2 (identify), word index 0 returns ID word 0, index 1 returns ID word 1, and index 2 returns 0. Each is zero-extended to 32 bits.
- R5: In identify state, word index 0x0E returns ID word 2 and index 0x0F returns ID word 3. If that ID word equals 0x00FF, the read returns array data as in R2 instead. Every other index also returns array data.
- R6: In command states 3 (program), 4 (chip erase) and 5 (sector erase), a read returns the status byte zero-extended. Bit 6 of the stored status is inverted at the same clock edge. Reads in any other state leave the status unchanged.
- R7: A pulse on `stat_load_i` replaces the status byte with `stat_value_i`. If a status read falls in the same cycle, the load wins.
- R8: In command state 6 (query), a word index above 0x52 returns 0. Otherwise the read returns the query table byte at that index. The table holds "Q","R","Y" at 0x10..0x12, log2 of the chip size at 0x27, the sector count minus one at 0x2D/0x2E, and the sector size divided by 256 at 0x2F/0x30.
- R9: The word index for identify and query decoding is the low 8 bits of the offset, shifted right by 1 for a 2-byte device or by 2 for a 4-byte device.
- R10: A read in command state 7 returns array data as in R2. In the cycle its data appears, `seq_reset_o` pulses high for one cycle. `seq_reset_o` is otherwise 0.
- R11: `rd_data_o` changes only on the clock after a read strobe and holds its value while `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en_i | input | 1 | Read strobe, one per read |
| cmd_i | input | 3 | Command state from the write sequencer |
| offset_i | input | ADDR_W | Byte offset of the read |
| width_i | input | 2 | Access width: 0 one byte, 1 two bytes, 2 four bytes |
| big_endian_i | input | 1 | Byte order of multi-byte array reads |
| arr_addr_o | output | CHIP_LOG2 | Wrapped array byte address |
| arr_bytes_i | input | 32 | Array bytes at arr_addr_o+0..+3, lowest address in bits 7:0 |
| stat_load_i | input | 1 | Load strobe for the status byte |
| stat_value_i | input | 8 | Value for the status load |
| rd_data_o | output | 32 | Registered read response |
| seq_reset_o | output | 1 | One-cycle request to reset the command sequencer |

## Verification
The hardest case to reach from the ports is the identify-mode fall-through. An index of 0x0E or 0x0F only returns array data when the matching ID parameter is 0x00FF. The bench therefore sets ID word 3 to 0x00FF and ID word 2 to a real value, so that two neighbouring reads take different paths. The bench also drives offsets above 0xFF and above the chip length. These show that the index is taken from the low offset bits while the array address wraps separately. Finally, the status toggle is only visible as a sequence: loads, repeated reads, and reads in other states are interleaved, and each status read is checked against the value implied by the ones before it.

// File: rtl/frm_pkg.sv
package frm_pkg;
  typedef enum logic [2:0] {
    ST_READ        = 3'd0,
    ST_ERASE_SETUP = 3'd1,
    ST_IDENT       = 3'd2,
    ST_PROGRAM     = 3'd3,
    ST_CHIP_ERASE  = 3'd4,
    ST_SECT_ERASE  = 3'd5,
    ST_QUERY       = 3'd6,
    ST_INVALID     = 3'd7
  } frm_cmd_e;

  typedef enum logic [1:0] {
    AW_8   = 2'd0,
    AW_16  = 2'd1,
    AW_32  = 2'd2,
    AW_RSV = 2'd3
  } frm_width_e;

  localparam logic [7:0] QUERY_LAST = 8'h52;
endpackage

// File: rtl/frm_lane_pack.sv
module frm_lane_pack
  import frm_pkg::*;
(
  input  logic [31:0] bytes_i,
  input  logic [1:0]  width_i,
  input  logic        big_endian_i,
  output logic [31:0] word_o
);
  logic [7:0] b0, b1, b2, b3;

  assign b0 = bytes_i[7:0];
  assign b1 = bytes_i[15:8];
  assign b2 = bytes_i[23:16];
  assign b3 = bytes_i[31:24];

  always_comb begin
    case (frm_width_e'(width_i))
      AW_8:    word_o = {24'h0, b0};
      AW_16:   word_o = big_endian_i ? {16'h0, b0, b1} : {16'h0, b1, b0};
      default: word_o = big_endian_i ? {b0, b1, b2, b3} : {b3, b2, b1, b0};
    endcase
  end
endmodule

// File: rtl/frm_query_rom.sv
module frm_query_rom #(
  parameter int CHIP_LOG2   = 12,
  parameter int SECTOR_LOG2 = 10
) (
  input  logic [7:0] idx_i,
  output logic [7:0] byte_o
);
  localparam int unsigned NSECT   = 1 << (CHIP_LOG2 - SECTOR_LOG2);
  localparam int unsigned SECTB   = 1 << SECTOR_LOG2;
  localparam logic [15:0] NSECT_M1 = 16'(NSECT - 1);
  localparam logic [23:0] SECT_SZ  = 24'(SECTB);

  always_comb begin
    case (idx_i)
      8'h10:   byte_o = 8'h51;
      8'h11:   byte_o = 8'h52;
      8'h12:   byte_o = 8'h59;
      8'h13:   byte_o = 8'h02;
      8'h15:   byte_o = 8'h31;
      8'h1B:   byte_o = 8'h27;
      8'h1C:   byte_o = 8'h36;
      8'h1F:   byte_o = 8'h07;
      8'h21:   byte_o = 8'h09;
      8'h22:   byte_o = 8'h0C;
      8'h23:   byte_o = 8'h01;
      8'h25:   byte_o = 8'h0A;
      8'h26:   byte_o = 8'h0D;
      8'h27:   byte_o = 8'(CHIP_LOG2);
      8'h28:   byte_o = 8'h02;
      8'h2C:   byte_o = 8'h01;
      8'h2D:   byte_o = NSECT_M1[7:0];
      8'h2E:   byte_o = NSECT_M1[15:8];
      8'h2F:   byte_o = SECT_SZ[15:8];
      8'h30:   byte_o = SECT_SZ[23:16];
      8'h31:   byte_o = 8'h50;
      8'h32:   byte_o = 8'h52;
      8'h33:   byte_o = 8'h49;
      8'h34:   byte_o = 8'h31;
      8'h35:   byte_o = 8'h30;
      default: byte_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/frm_status.sv
module frm_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] load_val_i,
  input  logic       rd_i,
  output logic [7:0] status_o
);
  logic [7:0] stat_q, stat_d;
  logic       stat_en;

  assign stat_en = load_i | rd_i;

  always_comb begin
    if (load_i)      stat_d = load_val_i;
    else if (rd_i)   stat_d = stat_q ^ 8'h40;
    else             stat_d = stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= 8'h00;
    else if (stat_en) stat_q <= stat_d;
  end

  assign status_o = stat_q;

  AST_TOGGLE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !load_i) |=> (status_o == ($past(status_o) ^ 8'h40))); // R6
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (status_o == $past(load_val_i))); // R7
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !rd_i) |=> $stable(status_o)); // R6
endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
  import frm_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          CHIP_LOG2   = 12,
  parameter int          SECTOR_LOG2 = 10,
  parameter int          DEV_BYTES   = 2,
  parameter logic [15:0] ID_W0       = 16'h0001,
  parameter logic [15:0] ID_W1       = 16'h227E,
  parameter logic [15:0] ID_W2       = 16'h2201,
  parameter logic [15:0] ID_W3       = 16'h00FF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en_i,
  input  logic [2:0]           cmd_i,
  input  logic [ADDR_W-1:0]    offset_i,
  input  logic [1:0]           width_i,
  input  logic                 big_endian_i,
  output logic [CHIP_LOG2-1:0] arr_addr_o,
  input  logic [31:0]          arr_bytes_i,
  input  logic                 stat_load_i,
  input  logic [7:0]           stat_value_i,
  output logic [31:0]          rd_data_o,
  output logic                 seq_reset_o
);
  localparam int IDX_SHIFT = (DEV_BYTES == 4) ? 2 : (DEV_BYTES == 2) ? 1 : 0;
  localparam logic [15:0] BLANK_ID = 16'h00FF;

  frm_cmd_e    cmd_e;
  logic [7:0]  widx;
  logic [31:0] arr_word;
  logic [7:0]  rom_byte;
  logic [7:0]  status;
  logic        stat_rd;
  logic        bad_state;
  logic [31:0] resp;
  logic [31:0] data_q, data_d;
  logic        rst_req_q, rst_req_d;

  assign cmd_e      = frm_cmd_e'(cmd_i);
  assign arr_addr_o = offset_i[CHIP_LOG2-1:0];
  assign widx       = offset_i[7:0] >> IDX_SHIFT;
  assign stat_rd    = rd_en_i && (cmd_e == ST_PROGRAM || cmd_e == ST_CHIP_ERASE ||
                                  cmd_e == ST_SECT_ERASE);

  frm_lane_pack u_pack (
    .bytes_i      (arr_bytes_i),
    .width_i      (width_i),
    .big_endian_i (big_endian_i),
    .word_o       (arr_word)
  );

  frm_query_rom #(.CHIP_LOG2(CHIP_LOG2), .SECTOR_LOG2(SECTOR_LOG2)) u_rom (
    .idx_i  (widx),
    .byte_o (rom_byte)
  );

  frm_status u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (stat_load_i),
    .load_val_i (stat_value_i),
    .rd_i       (stat_rd),
    .status_o   (status)
  );

  always_comb begin
    resp      = arr_word;
    bad_state = 1'b0;
    case (cmd_e)
      ST_READ, ST_ERASE_SETUP: resp = arr_word;
      ST_IDENT: begin
        case (widx)
          8'h00: resp = {16'h0, ID_W0};
          8'h01: resp = {16'h0, ID_W1};
          8'h02: resp = 32'h0;
          8'h0E: resp = (ID_W2 == BLANK_ID) ? arr_word : {16'h0, ID_W2};
          8'h0F: resp = (ID_W3 == BLANK_ID) ? arr_word : {16'h0, ID_W3};
          default: resp = arr_word;
        endcase
      end
      ST_PROGRAM, ST_CHIP_ERASE, ST_SECT_ERASE: resp = {24'h0, status};
      ST_QUERY: resp = (widx > QUERY_LAST) ? 32'h0 : {24'h0, rom_byte};
      default: begin
        resp      = arr_word;
        bad_state = 1'b1;
      end
    endcase
  end

  assign data_d    = rd_en_i ? resp : data_q;
  assign rst_req_d = rd_en_i & bad_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q    <= 32'h0;
      rst_req_q <= 1'b0;
    end else begin
      data_q    <= data_d;
      rst_req_q <= rst_req_d;
    end
  end

  assign rd_data_o   = data_q;
  assign seq_reset_o = rst_req_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o)); // R11
  AST_RESET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_reset_o |-> ($past(rd_en_i) && $past(cmd_i) == 3'd7)); // R10
  AST_QUERY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && cmd_e == ST_QUERY && widx > QUERY_LAST) |=> (rd_data_o == 32'h0)); // R8
  AST_STATUS_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (rd_data_o[31:8] == 24'h0)); // R6
endmodule

// File: tb/flash_read_mux_tb.sv
`timescale 1ns/1ps
module flash_read_mux_tb;
  localparam int CL = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_en;
  logic [2:0]  cmd;
  logic [15:0] off;
  logic [1:0]  wid;
  logic        be;
  logic [CL-1:0] aaddr;
  logic [31:0] abytes;
  logic        sload;
  logic [7:0]  sval;
  logic [31:0] rdata;
  logic        sreset;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  flash_read_mux u_dut (
    .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en), .cmd_i(cmd), .offset_i(off),
    .width_i(wid), .big_endian_i(be), .arr_addr_o(aaddr), .arr_bytes_i(abytes),
    .stat_load_i(sload), .stat_value_i(sval), .rd_data_o(rdata), .seq_reset_o(sreset)
  );

  function automatic logic [7:0] mem_at(logic [CL-1:0] a);
    return (a[7:0] ^ {a[11:8], a[11:8]}) + 8'h11;
  endfunction

  assign abytes = {mem_at(aaddr + 3), mem_at(aaddr + 2), mem_at(aaddr + 1), mem_at(aaddr)};

  function automatic logic [31:0] exp_arr(logic [15:0] o, logic [1:0] w, logic e);
    logic [CL-1:0] a;
    logic [7:0] c0, c1, c2, c3;
    a  = o[CL-1:0];
    c0 = mem_at(a); c1 = mem_at(a + 1); c2 = mem_at(a + 2); c3 = mem_at(a + 3);
    if (w == 2'd0) return {24'h0, c0};
    if (w == 2'd1) return e ? {16'h0, c0, c1} : {16'h0, c1, c0};
    return e ? {c0, c1, c2, c3} : {c3, c2, c1, c0};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_read(logic [2:0] c, logic [15:0] o, logic [1:0] w, logic e);
    @(negedge clk);
    cmd = c; off = o; wid = w; be = e; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_load(logic [7:0] v);
    @(negedge clk);
    sload = 1'b1; sval = v;
    @(negedge clk);
    sload = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 data in reset", rdata, 32'h0);
    check("R1 seq_reset in reset", {31'h0, sreset}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 data after release", rdata, 32'h0);
    do_read(3'd3, 16'h0, 2'd0, 1'b0);
    check("R1 status zero", rdata, 32'h0);
  endtask

  task automatic t_array;
    do_read(3'd0, 16'h0040, 2'd0, 1'b0); check("R2 byte", rdata, exp_arr(16'h0040, 2'd0, 1'b0));
    do_read(3'd0, 16'h0042, 2'd1, 1'b0); check("R2 half le", rdata, exp_arr(16'h0042, 2'd1, 1'b0));
    do_read(3'd0, 16'h0042, 2'd1, 1'b1); check("R2 half be", rdata, exp_arr(16'h0042, 2'd1, 1'b1));
    do_read(3'd0, 16'h0344, 2'd2, 1'b0); check("R2 word le", rdata, exp_arr(16'h0344, 2'd2, 1'b0));
    do_read(3'd0, 16'h0344, 2'd2, 1'b1); check("R2 word be", rdata, exp_arr(16'h0344, 2'd2, 1'b1));
    do_read(3'd1, 16'h0A08, 2'd2, 1'b0); check("R2 erase setup", rdata, exp_arr(16'h0A08, 2'd2, 1'b0));
  endtask

  task automatic t_wrap;
    do_read(3'd0, 16'h1010, 2'd0, 1'b0);
    check("R3 wrap data", rdata, {24'h0, mem_at(12'h010)});
    do_read(3'd0, 16'hF3A0, 2'd1, 1'b0);
    check("R3 wrap high", rdata, exp_arr(16'h03A0, 2'd1, 1'b0));
  endtask

  task automatic t_ident;
    do_read(3'd2, 16'h0000, 2'd1, 1'b0); check("R4 id0", rdata, 32'h0001);
    do_read(3'd2, 16'h0002, 2'd1, 1'b0); check("R4 id1", rdata, 32'h227E);
    do_read(3'd2, 16'h0004, 2'd1, 1'b0); check("R4 protect", rdata, 32'h0);
    do_read(3'd2, 16'h001C, 2'd1, 1'b0); check("R5 id2", rdata, 32'h2201);
    do_read(3'd2, 16'h001E, 2'd1, 1'b0); check("R5 id3 blank falls to array", rdata, exp_arr(16'h001E, 2'd1, 1'b0));
    do_read(3'd2, 16'h0010, 2'd1, 1'b1); check("R5 other index array", rdata, exp_arr(16'h0010, 2'd1, 1'b1));
  endtask

  task automatic t_scale;
    do_read(3'd2, 16'h0100, 2'd1, 1'b0); check("R9 low 8 bits only", rdata, 32'h0001);
    do_read(3'd2, 16'h0003, 2'd1, 1'b0); check("R9 shift by one", rdata, 32'h227E);
  endtask

  task automatic t_status;
    do_load(8'h80);
    do_read(3'd3, 16'h0, 2'd0, 1'b0); check("R7 loaded", rdata, 32'h80);
    do_read(3'd3, 16'h0, 2'd0, 1'b0); check("R6 toggled", rdata, 32'hC0);
    do_read(3'd0, 16'h0, 2'd0, 1'b0);
    do_read(3'd4, 16'h0, 2'd0, 1'b0); check("R6 no toggle on array read", rdata, 32'h80);
    do_read(3'd5, 16'h0, 2'd0, 1'b0); check("R6 sector erase status", rdata, 32'hC0);
    @(negedge clk);
    cmd = 3'd3; rd_en = 1'b1; sload = 1'b1; sval = 8'h00;
    @(negedge clk);
    rd_en = 1'b0; sload = 1'b0;
    do_read(3'd3, 16'h0, 2'd0, 1'b0); check("R7 load wins over toggle", rdata, 32'h00);
  endtask

  task automatic t_query;
    do_read(3'd6, 16'h0020, 2'd1, 1'b0); check("R8 Q", rdata, 32'h51);
    do_read(3'd6, 16'h0024, 2'd1, 1'b0); check("R8 Y", rdata, 32'h59);
    do_read(3'd6, 16'h004E, 2'd1, 1'b0); check("R8 size", rdata, 32'd12);
    do_read(3'd6, 16'h005A, 2'd1, 1'b0); check("R8 sectors", rdata, 32'h03);
    do_read(3'd6, 16'h005E, 2'd1, 1'b0); check("R8 sector size", rdata, 32'h04);
    do_read(3'd6, 16'h00A4, 2'd1, 1'b0); check("R8 last index", rdata, 32'h0);
    do_read(3'd6, 16'h00C0, 2'd1, 1'b0); check("R8 above bound", rdata, 32'h0);
  endtask

  task automatic t_invalid;
    do_read(3'd7, 16'h0088, 2'd2, 1'b0);
    check("R10 array data", rdata, exp_arr(16'h0088, 2'd2, 1'b0));
    check("R10 pulse", {31'h0, sreset}, 32'h1);
    @(negedge clk);
    check("R10 pulse ends", {31'h0, sreset}, 32'h0);
  endtask

  task automatic t_hold;
    logic [31:0] keep;
    do_read(3'd0, 16'h0055, 2'd2, 1'b1);
    keep = rdata;
    @(negedge clk);
    cmd = 3'd2; off = 16'h0000;
    repeat (3) @(negedge clk);
    check("R11 hold without strobe", rdata, keep);
  endtask

  initial begin
    rd_en = 0; cmd = 0; off = 0; wid = 0; be = 0; sload = 0; sval = 0; rst_n = 0;
    t_reset;
    t_array;
    t_wrap;
    t_ident;
    t_scale;
    t_status;
    t_query;
    t_invalid;
    t_hold;
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule